// File: doc/BRIEF.md
# CAN Error Status and Code Tracker

This block holds the protocol error state of a CAN node. The bit engine reports to it: the live transmit and receive error counts, a strobe for each good transmit and each good receive, a strobe with a code for each detected error, and the bus-off recovery progress events. The block turns these into an 8-bit status word. The word holds a 3-bit last-error code, two success flags and three error-state flags. The block also gives a 16-bit error counter readout.

The block does not decide when a counter moves, and it does not encode frames. It stores and reports the result. Software can rewrite the code field and the two success flags, but it cannot touch the state flags. A single status interrupt can be enabled in two groups:
- success and new codes;
- changes of the error state.

A master enable gates that interrupt. Reading the status word acknowledges it.

Top module: `can_err_tracker`

## Requirements
- R1: While reset is held, and for the first cycles after it, `stat_o`, `int_id_o` and `irq_o` are zero.
- R2: `stat_o[2:0]` holds the last-error code, with 1 stuff, 2 form, 3 acknowledge, 4 bit-1 (recessive sent, dominant seen), 5 bit-0 (dominant sent, recessive seen) and 6 CRC. An `err_evt_i` pulse with a code from 1 to 6 stores that code at the next edge. Codes 0 and 7 on that strobe change nothing.
- R3: `tx_ok_i` sets `stat_o[3]` and `rx_ok_i` sets `stat_o[4]` at the next edge. Each flag stays set until software writes it.
- R4: A write through `stat_wr_i` loads `stat_wdata_i[4:0]` into `stat_o[4:0]` and leaves `stat_o[7:5]` alone. A hardware event in the same cycle overrides the written value of the field it targets.
- R5: `stat_o[6]` (warning) is 1 one cycle after either error count is 96 or more, and 0 one cycle after both are below 96.
- R6: `stat_o[5]` (passive) is 1 one cycle after either error count exceeds 127, and 0 otherwise.
- R7: `stat_o[7]` (bus-off) sets one cycle after the transmit count exceeds 255. It then holds until a `recov_done_i` pulse clears it.
- R8: While bus-off is set, a `recov_tick_i` pulse (one run of 11 recessive bits) writes code 5. When bus-off is clear, the tick is ignored. An error event in the same cycle takes priority over the tick.
- R9: `errcnt_o[7:0]` is the low byte of the transmit count and `errcnt_o[14:8]` is receive count bits 6:0. `errcnt_o[15]` is 1 when the receive count exceeds 127.
- R10: If control bit 2 is set, a success strobe or a hardware-written code raises the pending status interrupt. If control bit 3 is set, any change of `stat_o[7:5]` raises it.
- R11: `irq_o` is pending AND control bit 1. `int_id_o` is 16'h8000 while `irq_o` is high, else 0. The pending state is kept while bit 1 is 0.
- R12: A `stat_rd_i` pulse clears the pending interrupt. If a new cause occurs in the same cycle, the pending interrupt stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_cnt_i | input | 9 | Transmit error count from the bit engine |
| rx_cnt_i | input | 8 | Receive error count from the bit engine |
| tx_ok_i | input | 1 | Frame sent without error |
| rx_ok_i | input | 1 | Frame received without error |
| err_evt_i | input | 1 | Error detected strobe |
| err_code_i | input | 3 | Code of the detected error |
| recov_tick_i | input | 1 | Eleven recessive bits seen during recovery |
| recov_done_i | input | 1 | Bus-off recovery complete |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 3 | Control bits 3:1 (error, status-change, module enables) |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 5 | Value for status bits 4:0 |
| stat_rd_i | input | 1 | Status read strobe, acknowledges the interrupt |
| stat_o | output | 8 | Status word |
| errcnt_o | output | 16 | Error counter readout |
| int_id_o | output | 16 | Interrupt identifier |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume:
- the strobes are single-cycle pulses sampled at the clock edge;
- the error counts are stable around that edge;
- recovery ticks and done pulses mean something only while bus-off is set.

The random stimulus changes the counters only now and then, over the range 0 to 300. This crosses every threshold, and bus-off is entered often. The random stimulus also fires strobes with codes 0 to 7, so the ignored codes get exercised. Directed sequences force the priority collisions: a write against an event, a tick against an error, and a read against a new cause.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

  typedef logic [2:0] lec_t;

  localparam lec_t LEC_NONE = 3'd0;
  localparam lec_t LEC_BIT0 = 3'd5;
  localparam lec_t LEC_MAXV = 3'd6;

  localparam logic [15:0] INT_ID_STATUS = 16'h8000;

  typedef struct packed {
    logic boff;
    logic ewarn;
    logic epass;
  } err_flags_t;

endpackage

// File: rtl/can_err_flags.sv
module can_err_flags
  import can_err_pkg::*;
#(
  parameter int TX_W     = 9,
  parameter int RX_W     = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 127,
  parameter int BOFF_LIM = 255
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TX_W-1:0] tx_cnt,
  input  logic [RX_W-1:0] rx_cnt,
  input  logic            recov_done,
  output err_flags_t      flags_q,
  output logic            flags_chg
);

  localparam logic [TX_W-1:0] TX_WARN = TX_W'(WARN_LIM);
  localparam logic [RX_W-1:0] RX_WARN = RX_W'(WARN_LIM);
  localparam logic [TX_W-1:0] TX_PASS = TX_W'(PASS_LIM);
  localparam logic [RX_W-1:0] RX_PASS = RX_W'(PASS_LIM);
  localparam logic [TX_W-1:0] TX_BOFF = TX_W'(BOFF_LIM);

  err_flags_t flags_d;

  always_comb begin
    flags_d.ewarn = (tx_cnt >= TX_WARN) || (rx_cnt >= RX_WARN);
    flags_d.epass = (tx_cnt > TX_PASS) || (rx_cnt > RX_PASS);
    if (flags_q.boff) flags_d.boff = !recov_done;
    else              flags_d.boff = (tx_cnt > TX_BOFF);
    flags_chg = (flags_d != flags_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flags_q <= '0;
    else if (flags_chg) flags_q <= flags_d;
  end

  // R7
  boff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.boff && !recov_done |=> flags_q.boff);
  // R5
  warn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt >= TX_WARN) |=> flags_q.ewarn);
  // R6
  pass_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= TX_PASS) && (rx_cnt <= RX_PASS) |=> !flags_q.epass);

endmodule

// File: rtl/can_err_code.sv
module can_err_code
  import can_err_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_tx_ok,
  input  logic       ev_rx_ok,
  input  logic       err_evt,
  input  lec_t       err_code,
  input  logic       recov_tick,
  input  logic       boff,
  input  logic       sw_wr,
  input  logic [4:0] sw_data,
  output lec_t       lec_q,
  output logic       txok_q,
  output logic       rxok_q,
  output logic       hw_code_wr
);

  lec_t lec_d;
  logic txok_d, rxok_d;
  logic err_ok, tick_ok, upd_en;

  always_comb begin
    err_ok     = err_evt && (err_code != LEC_NONE) && (err_code <= LEC_MAXV);
    tick_ok    = recov_tick && boff;
    hw_code_wr = err_ok || tick_ok;
    if (err_ok)       lec_d = err_code;
    else if (tick_ok) lec_d = LEC_BIT0;
    else if (sw_wr)   lec_d = sw_data[2:0];
    else              lec_d = lec_q;
    txok_d = ev_tx_ok || (sw_wr ? sw_data[3] : txok_q);
    rxok_d = ev_rx_ok || (sw_wr ? sw_data[4] : rxok_q);
    upd_en = hw_code_wr || sw_wr || ev_tx_ok || ev_rx_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lec_q  <= LEC_NONE;
      txok_q <= 1'b0;
      rxok_q <= 1'b0;
    end else if (upd_en) begin
      lec_q  <= lec_d;
      txok_q <= txok_d;
      rxok_q <= rxok_d;
    end
  end

  // R2
  lec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt && (err_code != 3'd0) && (err_code != 3'd7) |=> lec_q == $past(err_code));
  // R3
  txok_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_ok |=> txok_q);
  // R8
  recov_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recov_tick && boff && !err_evt |=> lec_q == 3'd5);

endmodule

// File: rtl/can_err_irq.sv
module can_err_irq
  import can_err_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mod_en,
  input  logic        sc_en,
  input  logic        err_en,
  input  logic        ok_evt,
  input  logic        hw_code_wr,
  input  logic        flags_chg,
  input  logic        rd_ack,
  output logic        irq,
  output logic [15:0] int_id
);

  logic pend_q, pend_d, cause, pend_en;

  always_comb begin
    cause   = (sc_en && (ok_evt || hw_code_wr)) || (err_en && flags_chg);
    pend_d  = cause || (pend_q && !rd_ack);
    pend_en = cause || rd_ack;
    irq     = pend_q && mod_en;
    int_id  = irq ? INT_ID_STATUS : 16'h0000;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  // R12
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && !cause |=> !pend_q);
  // R10
  sc_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_en && ok_evt |=> pend_q);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !rd_ack |=> pend_q);

endmodule

// File: rtl/can_err_tracker.sv
module can_err_tracker
  import can_err_pkg::*;
#(
  parameter int TX_W     = 9,
  parameter int RX_W     = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 127,
  parameter int BOFF_LIM = 255
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TX_W-1:0] tx_cnt_i,
  input  logic [RX_W-1:0] rx_cnt_i,
  input  logic            tx_ok_i,
  input  logic            rx_ok_i,
  input  logic            err_evt_i,
  input  logic [2:0]      err_code_i,
  input  logic            recov_tick_i,
  input  logic            recov_done_i,
  input  logic            ctrl_wr_i,
  input  logic [3:1]      ctrl_wdata_i,
  input  logic            stat_wr_i,
  input  logic [4:0]      stat_wdata_i,
  input  logic            stat_rd_i,
  output logic [7:0]      stat_o,
  output logic [15:0]     errcnt_o,
  output logic [15:0]     int_id_o,
  output logic            irq_o
);

  localparam logic [RX_W-1:0] RX_PASS = RX_W'(PASS_LIM);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [3:1] ctrl_q;
  err_flags_t flags_q;
  logic       flags_chg, hw_code_wr, txok_q, rxok_q;
  lec_t       lec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)     ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= ctrl_wdata_i;
  end

  can_err_flags #(
    .TX_W(TX_W), .RX_W(RX_W), .WARN_LIM(WARN_LIM),
    .PASS_LIM(PASS_LIM), .BOFF_LIM(BOFF_LIM)
  ) u_flags (
    .clk(clk), .rst_n(rst_int_n), .tx_cnt(tx_cnt_i), .rx_cnt(rx_cnt_i),
    .recov_done(recov_done_i), .flags_q(flags_q), .flags_chg(flags_chg)
  );

  can_err_code u_code (
    .clk(clk), .rst_n(rst_int_n), .ev_tx_ok(tx_ok_i), .ev_rx_ok(rx_ok_i),
    .err_evt(err_evt_i), .err_code(err_code_i), .recov_tick(recov_tick_i),
    .boff(flags_q.boff), .sw_wr(stat_wr_i), .sw_data(stat_wdata_i),
    .lec_q(lec_q), .txok_q(txok_q), .rxok_q(rxok_q), .hw_code_wr(hw_code_wr)
  );

  can_err_irq u_irq (
    .clk(clk), .rst_n(rst_int_n), .mod_en(ctrl_q[1]), .sc_en(ctrl_q[2]),
    .err_en(ctrl_q[3]), .ok_evt(tx_ok_i || rx_ok_i), .hw_code_wr(hw_code_wr),
    .flags_chg(flags_chg), .rd_ack(stat_rd_i), .irq(irq_o), .int_id(int_id_o)
  );

  assign stat_o   = {flags_q.boff, flags_q.ewarn, flags_q.epass, rxok_q, txok_q, lec_q};
  assign errcnt_o = {(rx_cnt_i > RX_PASS), rx_cnt_i[6:0], tx_cnt_i[7:0]};

  // R4
  sw_flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    stat_wr_i && !flags_chg |=> stat_o[7:5] == $past(stat_o[7:5]));

endmodule

// File: tb/can_err_tracker_tb.sv
module can_err_tracker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [8:0] tx_cnt;
  logic [7:0] rx_cnt;
  logic tx_ok, rx_ok, err_evt, tick, done, cwr, swr, srd;
  logic [2:0] code, cwd;
  logic [4:0] swd;
  logic [7:0] stat;
  logic [15:0] errcnt, intid;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // model state
  logic [2:0] m_lec;
  logic m_txok, m_rxok, m_boff, m_ewarn, m_epass, m_pend;
  logic [3:1] m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_err_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .tx_cnt_i(tx_cnt), .rx_cnt_i(rx_cnt),
    .tx_ok_i(tx_ok), .rx_ok_i(rx_ok), .err_evt_i(err_evt), .err_code_i(code),
    .recov_tick_i(tick), .recov_done_i(done), .ctrl_wr_i(cwr), .ctrl_wdata_i(cwd),
    .stat_wr_i(swr), .stat_wdata_i(swd), .stat_rd_i(srd),
    .stat_o(stat), .errcnt_o(errcnt), .int_id_o(intid), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    tx_ok = 0; rx_ok = 0; err_evt = 0; code = 0; tick = 0; done = 0;
    cwr = 0; cwd = 0; swr = 0; swd = 0; srd = 0;
  endtask

  function automatic logic [7:0] exp_stat();
    return {m_boff, m_ewarn, m_epass, m_rxok, m_txok, m_lec};
  endfunction

  task automatic model_update();
    logic err_ok, tick_ok, b_n, w_n, p_n, chg, cause;
    err_ok  = err_evt && code != 3'd0 && code != 3'd7;
    tick_ok = tick && m_boff;
    w_n = (tx_cnt >= 96) || (rx_cnt >= 96);
    p_n = (tx_cnt > 127) || (rx_cnt > 127);
    b_n = m_boff ? !done : (tx_cnt > 255);
    chg = {b_n, w_n, p_n} != {m_boff, m_ewarn, m_epass};
    cause = (m_ctrl[2] && (tx_ok || rx_ok || err_ok || tick_ok)) || (m_ctrl[3] && chg);
    if (err_ok) m_lec = code;
    else if (tick_ok) m_lec = 3'd5;
    else if (swr) m_lec = swd[2:0];
    m_txok = tx_ok || (swr ? swd[3] : m_txok);
    m_rxok = rx_ok || (swr ? swd[4] : m_rxok);
    m_boff = b_n; m_ewarn = w_n; m_epass = p_n;
    m_pend = cause || (m_pend && !srd);
    if (cwr) m_ctrl = cwd;
  endtask

  task automatic compare_all();
    chk("R2 code", {13'd0, stat[2:0]}, {13'd0, m_lec});
    chk("R3 ok flags", {14'd0, stat[4:3]}, {14'd0, m_rxok, m_txok});
    chk("R5/R6/R7 state flags", {13'd0, stat[7:5]}, {13'd0, m_boff, m_ewarn, m_epass});
    chk("R9 errcnt", errcnt, {rx_cnt > 127, rx_cnt[6:0], tx_cnt[7:0]});
    chk("R11 irq", {15'd0, irq}, {15'd0, m_pend && m_ctrl[1]});
    chk("R11 int_id", intid, (m_pend && m_ctrl[1]) ? 16'h8000 : 16'h0000);
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; tx_cnt = 0; rx_cnt = 0; idle();
    m_lec = 0; m_txok = 0; m_rxok = 0; m_boff = 0; m_ewarn = 0; m_epass = 0;
    m_pend = 0; m_ctrl = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 stat", {8'd0, stat}, 16'd0);
    chk("R1 int_id", intid, 16'd0);
    chk("R1 irq", {15'd0, irq}, 16'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 stat after release", {8'd0, stat}, 16'd0);

    // enable all interrupt groups
    cwr = 1; cwd = 3'b111; step();
    // R2 each code and ignored codes 0/7
    for (int c = 0; c < 8; c++) begin err_evt = 1; code = 3'(c); step(); end
    // R4 software write versus a transmit event in the same cycle
    swr = 1; swd = 5'b10010; tx_ok = 1; step();
    chk("R4 write with event", {8'd0, stat}, {8'd0, 3'b000, 5'b11010});
    swr = 1; swd = 5'b00000; step();
    // R12 read clears, read with cause keeps
    srd = 1; step();
    chk("R12 cleared", {15'd0, irq}, 16'd0);
    srd = 1; rx_ok = 1; step();
    chk("R12 set wins", {15'd0, irq}, 16'd1);
    // R11 gating by module enable
    cwr = 1; cwd = 3'b110; step();
    chk("R11 gated", intid, 16'd0);
    cwr = 1; cwd = 3'b111; step();
    // R7 enter bus-off, R8 tick writes code 5
    tx_cnt = 9'd300; step(); step();
    chk("R7 bus-off", {15'd0, stat[7]}, 16'd1);
    tx_cnt = 9'd0; step();
    chk("R7 hold", {15'd0, stat[7]}, 16'd1);
    tick = 1; step();
    chk("R8 tick", {13'd0, stat[2:0]}, 16'd5);
    tick = 1; err_evt = 1; code = 3'd2; step();
    chk("R8 error over tick", {13'd0, stat[2:0]}, 16'd2);
    done = 1; step();
    chk("R7 recovered", {15'd0, stat[7]}, 16'd0);
    swr = 1; swd = 5'd1; step();
    tick = 1; step();
    chk("R8 tick ignored", {13'd0, stat[2:0]}, 16'd1);
    // R10 state change raises only with error enable
    srd = 1; cwr = 1; cwd = 3'b011; step();
    rx_cnt = 8'd100; step(); step();
    chk("R10 no raise", {15'd0, irq}, 16'd0);
    cwr = 1; cwd = 3'b101; step();
    rx_cnt = 8'd0; step(); step();
    chk("R10 raise", {15'd0, irq}, 16'd1);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 7) == 0) tx_cnt = 9'($urandom_range(0, 300));
      if ($urandom_range(0, 7) == 0) rx_cnt = 8'($urandom_range(0, 255));
      tx_ok   = ($urandom_range(0, 5) == 0);
      rx_ok   = ($urandom_range(0, 5) == 0);
      err_evt = ($urandom_range(0, 3) == 0);
      code    = 3'($urandom_range(0, 7));
      tick    = ($urandom_range(0, 3) == 0);
      done    = ($urandom_range(0, 15) == 0);
      cwr     = ($urandom_range(0, 31) == 0);
      cwd     = 3'($urandom_range(0, 7));
      swr     = ($urandom_range(0, 15) == 0);
      swd     = 5'($urandom_range(0, 31));
      srd     = ($urandom_range(0, 7) == 0);
      step();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule